// File: doc/BRIEF.md
# Context-Tagged Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It keeps sixteen translations, and any translation may sit in any slot. Each slot holds a page number, a frame number, an 8-bit address-space tag, a valid flag, a write-permission flag and a modified flag. A lookup compares the page number and the current address-space tag against every slot at once. In the same cycle it returns the physical address, a miss, or a protection fault. The requester uses a miss or a fault to cancel the instruction's register write.

Each slot is tagged with the address space that owned it when it was written. Translations for several processes can therefore live side by side, and switching processes only needs a write to the current-context register, not a flush. Software loads new translations through a refill port, which picks the slot to replace in round-robin order. An invalidate-all input empties the whole buffer. This block does not walk page tables; it only reports the miss.

Top module: `ctx_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the 20-bit frame number of the matching slot in bits 31:12, with bits 11:0 copied unchanged from `lk_vaddr`. The page number used for matching is `lk_vaddr[31:12]`.
- R2: A lookup hits only if a slot is valid, its page number equals `lk_vaddr[31:12]`, and its address-space tag equals the current-context register. Otherwise `lk_miss` is 1 in the same cycle as `lk_en`. While `lk_en` is high, exactly one of `lk_hit`, `lk_miss` and `lk_prot` is 1.
- R3: The current-context register resets to 0 and loads `ctx_wr_data` at a clock edge where `ctx_wr_en` is 1. A refill tags its slot with the value this register holds in the refill cycle.
- R4: A store (`lk_store`=1) that hits a slot with write permission sets that slot's modified flag at the next edge. `lk_dirty` shows the hit slot's modified flag as it stood before the access. A load never sets the flag.
- R5: A store that matches a slot whose write permission is 0 raises `lk_prot` instead of `lk_hit`, drives `lk_paddr` to 0 and leaves the modified flag unchanged. A load to the same slot hits.
- R6: The refill slot pointer is 0 after reset. Each refill writes slot `pointer` and then advances the pointer by one, wrapping from 15 to 0. The 17th refill after reset therefore evicts the first.
- R7: `inv_all` clears every valid flag and returns the refill pointer to 0 at the same edge. A refill requested in that same cycle is dropped.
- R8: When more than one slot matches, only the lowest-numbered slot supplies the frame number, permission and modified flag.
- R9: With `lk_en`=0, `lk_hit`, `lk_miss` and `lk_prot` are all 0. Whenever `lk_hit` is 0, `lk_paddr` and `lk_dirty` are 0.
- R10: After reset every slot is invalid, so any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_wr_en | input | 1 | Load the current-context register |
| ctx_wr_data | input | 8 | New address-space tag |
| lk_en | input | 1 | Lookup request this cycle |
| lk_store | input | 1 | Lookup is for a store (1) or a load (0) |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching translation (exception) |
| lk_prot | output | 1 | Store to a page without write permission (exception) |
| lk_dirty | output | 1 | Modified flag of the hit slot before this access |
| lk_paddr | output | 32 | Translated physical address, 0 unless hit |
| rf_en | input | 1 | Write a new translation into the slot at the round-robin pointer |
| rf_vpn | input | 20 | Page number of the new translation |
| rf_pfn | input | 20 | Frame number of the new translation |
| rf_wperm | input | 1 | Write permission of the new translation |
| rf_dirty | input | 1 | Initial modified flag of the new translation |
| inv_all | input | 1 | Invalidate every slot and reset the refill pointer |

## Verification
The hardest conditions to reach from the ports are a slot that is truly evicted by pointer wrap, and proof that invalidate-all resets the pointer. Neither the pointer nor the slot index is visible. The stimulus first fills the buffer so that a 17th refill lands on the slot holding the first translation, and shows that translation is gone while its neighbour survives. After an invalidate, it writes fifteen filler pages and then the same page number twice. Only a pointer restarted at 0 puts the second copy in slot 0, and the lowest-index rule then makes that second frame number visible. Duplicate page numbers within one context also expose the lowest-index rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W  = 32;
    parameter int OFS_W = 12;
    parameter int PFN_W = 20;
    parameter int CTX_W = 8;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PA_W  = PFN_W + OFS_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             wperm;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2,
        RES_PROT = 2'd3
    } lk_res_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic             dset_en,
    input  logic [IDX_W-1:0] dset_idx,
    input  logic [VPN_W-1:0] cmp_vpn,
    input  logic [CTX_W-1:0] cmp_ctx,
    output logic [N_ENT-1:0] match,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PFN_W-1:0] rd_pfn,
    output logic             rd_wperm,
    output logic             rd_dirty
);
    tlb_ent_t ent_q [N_ENT];

    // storage: invalidate beats refill, refill beats the modified-flag update
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (clr_all) begin
                ent_q[i].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_ent;
            end else if (dset_en && (dset_idx == IDX_W'(i))) begin
                ent_q[i].dirty <= 1'b1;
            end
        end
    end

    // one comparator per slot
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent_q[g].valid
                       && (ent_q[g].vpn == cmp_vpn)
                       && (ent_q[g].ctx == cmp_ctx);
    end

    always_comb begin
        rd_pfn   = ent_q[rd_idx].pfn;
        rd_wperm = ent_q[rd_idx].wperm;
        rd_dirty = ent_q[rd_idx].dirty;
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] match,
    output logic             any,
    output logic [IDX_W-1:0] sel_idx
);
    // scan from the top so the lowest matching index is the last to win
    always_comb begin
        any     = 1'b0;
        sel_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                any     = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctx_wr_en,
    input  logic [tlb_pkg::CTX_W-1:0] ctx_wr_data,
    input  logic                      lk_en,
    input  logic                      lk_store,
    input  logic [tlb_pkg::VA_W-1:0]  lk_vaddr,
    output logic                      lk_hit,
    output logic                      lk_miss,
    output logic                      lk_prot,
    output logic                      lk_dirty,
    output logic [tlb_pkg::PA_W-1:0]  lk_paddr,
    input  logic                      rf_en,
    input  logic [tlb_pkg::VPN_W-1:0] rf_vpn,
    input  logic [tlb_pkg::PFN_W-1:0] rf_pfn,
    input  logic                      rf_wperm,
    input  logic                      rf_dirty,
    input  logic                      inv_all
);
    localparam int IDX_W = $clog2(N_ENT);

    logic [CTX_W-1:0] ctx_q;
    logic [N_ENT-1:0] match;
    logic             any;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] vic_idx;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_wperm;
    logic             sel_dirty;
    logic             wr_go;
    tlb_ent_t         new_ent;
    lk_res_e          res;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (ctx_wr_en) begin
            ctx_q <= ctx_wr_data;
        end
    end

    assign wr_go = rf_en && !inv_all;

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.dirty = rf_dirty;
        new_ent.wperm = rf_wperm;
        new_ent.ctx   = ctx_q;
        new_ent.vpn   = rf_vpn;
        new_ent.pfn   = rf_pfn;
    end

    tlb_cam #(.N_ENT(N_ENT)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (inv_all),
        .wr_en    (wr_go),
        .wr_idx   (vic_idx),
        .wr_ent   (new_ent),
        .dset_en  (lk_store && (res == RES_HIT)),
        .dset_idx (sel_idx),
        .cmp_vpn  (lk_vaddr[VA_W-1:OFS_W]),
        .cmp_ctx  (ctx_q),
        .match    (match),
        .rd_idx   (sel_idx),
        .rd_pfn   (sel_pfn),
        .rd_wperm (sel_wperm),
        .rd_dirty (sel_dirty)
    );

    tlb_pick #(.N_ENT(N_ENT)) u_pick (
        .match   (match),
        .any     (any),
        .sel_idx (sel_idx)
    );

    tlb_victim #(.N_ENT(N_ENT)) u_vic (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (inv_all),
        .adv   (wr_go),
        .ptr   (vic_idx)
    );

    // classify the lookup
    always_comb begin
        if (!lk_en) begin
            res = RES_NONE;
        end else if (!any) begin
            res = RES_MISS;
        end else if (lk_store && !sel_wperm) begin
            res = RES_PROT;
        end else begin
            res = RES_HIT;
        end
    end

    // drive the outputs from the classification
    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_prot  = 1'b0;
        lk_dirty = 1'b0;
        lk_paddr = '0;
        unique case (res)
            RES_NONE: ;
            RES_MISS: lk_miss = 1'b1;
            RES_PROT: lk_prot = 1'b1;
            RES_HIT: begin
                lk_hit   = 1'b1;
                lk_dirty = sel_dirty;
                lk_paddr = {sel_pfn, lk_vaddr[OFS_W-1:0]};
            end
        endcase
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctx_wr_en,
    input logic             lk_en,
    input logic             lk_store,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_prot,
    input logic             lk_dirty,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             rf_en,
    input logic             inv_all
);
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> ($countones({lk_hit, lk_miss, lk_prot}) == 1)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |-> (!lk_hit && !lk_miss && !lk_prot)); // R9

    AST_ZERO_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && !lk_dirty)); // R9

    AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0])); // R1

    AST_PROT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prot |-> lk_store); // R5

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (!lk_en || lk_miss)); // R7

    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && lk_store && lk_hit && !rf_en && !inv_all && !ctx_wr_en)
        |=> (!(lk_en && lk_hit
               && (lk_vaddr[VA_W-1:OFS_W] == $past(lk_vaddr[VA_W-1:OFS_W])))
             || lk_dirty)); // R4
endmodule

bind ctx_tlb tlb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx_wr_en (ctx_wr_en),
    .lk_en     (lk_en),
    .lk_store  (lk_store),
    .lk_vaddr  (lk_vaddr),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_prot   (lk_prot),
    .lk_dirty  (lk_dirty),
    .lk_paddr  (lk_paddr),
    .rf_en     (rf_en),
    .inv_all   (inv_all)
);

// File: tb/sim_ctx_tlb.sv
`timescale 1ns/1ps
module sim_ctx_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_wr_en = 1'b0;
    logic [7:0]  ctx_wr_data = '0;
    logic        lk_en = 1'b0;
    logic        lk_store = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_prot, lk_dirty;
    logic [31:0] lk_paddr;
    logic        rf_en = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_pfn = '0;
    logic        rf_wperm = 1'b0;
    logic        rf_dirty = 1'b0;
    logic        inv_all = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ctx_tlb u0 (
        .clk(clk), .rst_n(rst_n), .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data),
        .lk_en(lk_en), .lk_store(lk_store), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot(lk_prot),
        .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
        .rf_wperm(rf_wperm), .rf_dirty(rf_dirty), .inv_all(inv_all)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  ctx;
        logic [31:0] va;
        logic        st;
        logic        hit;
        logic        miss;
        logic        prot;
        logic [31:0] pa;
        logic        dty;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 8'h11, 32'h00010ABC, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAAAAAABC, 1'b0}, // R1
        '{4'd3, 8'h22, 32'h00010ABC, 1'b0, 1'b1, 1'b0, 1'b0, 32'h55555ABC, 1'b0}, // R3
        '{4'd2, 8'h33, 32'h00010ABC, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R2
        '{4'd5, 8'h11, 32'h00020FFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'h12345FFF, 1'b0}, // R5
        '{4'd5, 8'h11, 32'h00020FFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000000, 1'b0}, // R5
        '{4'd4, 8'h11, 32'h00030000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0F0F0000, 1'b0}, // R4
        '{4'd4, 8'h11, 32'h00030004, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0F0F0004, 1'b1}, // R4
        '{4'd8, 8'h22, 32'h00040123, 1'b0, 1'b1, 1'b0, 1'b0, 32'h77777123, 1'b0}, // R8
        '{4'd2, 8'h22, 32'h00050000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R2
        '{4'd2, 8'h11, 32'h00040123, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R2
        '{4'd4, 8'h11, 32'h00010000, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAAAAA000, 1'b0}, // R4
        '{4'd4, 8'h11, 32'h00010000, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAAAAA000, 1'b0}, // R4
        '{4'd5, 8'h11, 32'h00020000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h12345000, 1'b0}  // R5
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_ctx(input logic [7:0] c);
        ctx_wr_en = 1'b1;
        ctx_wr_data = c;
        @(posedge clk);
        #1 ctx_wr_en = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic wp);
        rf_en = 1'b1;
        rf_vpn = vpn;
        rf_pfn = pfn;
        rf_wperm = wp;
        rf_dirty = 1'b0;
        @(posedge clk);
        #1 rf_en = 1'b0;
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic st,
                        input logic eh, input logic em, input logic ep,
                        input logic [31:0] epa, input logic ed);
        lk_en = 1'b1;
        lk_store = st;
        lk_vaddr = va;
        #1;
        chk({tag, " flags"}, {61'd0, lk_hit, lk_miss, lk_prot}, {61'd0, eh, em, ep});
        chk({tag, " paddr"}, {32'd0, lk_paddr}, {32'd0, epa});
        chk({tag, " dirty"}, {63'd0, lk_dirty}, {63'd0, ed});
        @(posedge clk);
        #1 lk_en = 1'b0;
        lk_store = 1'b0;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: empty after reset
        look("R10 reset miss", 32'h00000000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
        look("R10 reset miss b", 32'h00ABC000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);

        // R3: context register resets to 0, refill in slot 0
        refill(20'h00ABC, 20'h00001, 1'b1);
        look("R3 ctx reset", 32'h00ABC010, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00001010, 1'b0);

        set_ctx(8'h11);
        refill(20'h00010, 20'hAAAAA, 1'b1);   // slot 1
        refill(20'h00020, 20'h12345, 1'b0);   // slot 2
        refill(20'h00030, 20'h0F0F0, 1'b1);   // slot 3
        set_ctx(8'h22);
        refill(20'h00010, 20'h55555, 1'b1);   // slot 4
        refill(20'h00040, 20'h77777, 1'b1);   // slot 5
        refill(20'h00040, 20'h66666, 1'b1);   // slot 6, duplicate

        for (int v = 0; v < NV; v++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[v].req, v);
            set_ctx(VECS[v].ctx);
            look(t, VECS[v].va, VECS[v].st, VECS[v].hit, VECS[v].miss,
                 VECS[v].prot, VECS[v].pa, VECS[v].dty);
        end

        // R9: idle lookup stays quiet
        lk_en = 1'b0;
        lk_vaddr = 32'h00010000;
        #1;
        chk("R9 idle flags", {61'd0, lk_hit, lk_miss, lk_prot}, 64'd0);
        chk("R9 idle paddr", {32'd0, lk_paddr}, 64'd0);
        @(posedge clk);
        #1;

        // R6: pointer is 7; fill slots 7..15, then wrap to slot 0
        set_ctx(8'h11);
        for (int k = 0; k < 9; k++) refill(20'h00100 + 20'(k), 20'h00200 + 20'(k), 1'b1);
        refill(20'h00999, 20'hBBBBB, 1'b1);
        look("R6 new hit", 32'h00999123, 1'b0, 1'b1, 1'b0, 1'b0, 32'hBBBBB123, 1'b0);
        look("R6 neighbour kept", 32'h00010004, 1'b0, 1'b1, 1'b0, 1'b0, 32'hAAAAA004, 1'b0);
        look("R6 last filler", 32'h00108000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00208000, 1'b0);
        set_ctx(8'h00);
        look("R6 evicted", 32'h00ABC010, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);

        // R7: invalidate with a simultaneous refill
        set_ctx(8'h11);
        inv_all = 1'b1;
        rf_en = 1'b1;
        rf_vpn = 20'h00888;
        rf_pfn = 20'h00888;
        rf_wperm = 1'b1;
        @(posedge clk);
        #1 inv_all = 1'b0;
        rf_en = 1'b0;
        look("R7 cleared", 32'h00999000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
        look("R7 refill dropped", 32'h00888000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
        look("R7 cleared b", 32'h00010000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);

        // R7 and R8: pointer restarts at 0, so the second copy lands in slot 0
        for (int k = 0; k < 15; k++) refill(20'h00300 + 20'(k), 20'h00400 + 20'(k), 1'b1);
        refill(20'h00555, 20'hCCCCC, 1'b1);
        refill(20'h00555, 20'hDDDDD, 1'b1);
        look("R7 pointer reset", 32'h00555ABC, 1'b0, 1'b1, 1'b0, 1'b0, 32'hDDDDDABC, 1'b0);
        look("R8 filler slot", 32'h00301000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00401000, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule